// File: doc/BRIEF.md
# Atomic Semaphore Flag and Address Lock Unit

This unit sits on the memory side of a split-transaction bus. On such a bus a test-and-set built from a separate read and write is not atomic. Other queued requests can reach the same location between the two halves, and the risk grows as the queues fill with pending work. The unit removes that gap in two ways. First, it keeps a small array of one-bit semaphore flags, and a single request both reads and sets a flag in the same clock cycle. Second, it holds a small table of address locks. A requester opens a lock with an explicitly marked locked read and closes it with its own write.

Requests arrive one per cycle and carry an operation code, a source ID and an address. Every request gets one completion on the following cycle. The completion returns the source ID, a status (accepted or retry) and, for a flag operation, the flag's previous value. A requester that gets a retry issues the request again later. The unit never stalls the bus. Requests are handled strictly in the order they arrive.

Top module: `tas_unit`

## Requirements
- R1: While reset is asserted and until the first request after reset, `cpl_valid` is 0. After reset every flag reads 0 and no address is locked.
- R2: Each cycle with `req_valid`=1 produces exactly one completion in the next cycle, and that completion carries the request's `req_src`. A cycle with `req_valid`=0 produces no completion in the next cycle.
- R3: Op code 0 (test-and-set) returns the flag's previous value in `cpl_data` and leaves the flag at 1. The flag index is the low log2(NUM_FLAGS) bits of `req_addr`.
- R4: Op code 1 (clear) sets the addressed flag to 0 and completes with `cpl_data`=0.
- R5: Requests are served in arrival order, one per cycle. Between two clears of a flag, at most one test-and-set on that flag returns 0. This holds even when the test-and-set requests arrive in back-to-back cycles from different sources.
- R6: Op code 2 (locked read) to an unlocked address, when a lock entry is free, completes with status accepted and locks the address to the requesting source. A repeated locked read from the owner is also accepted.
- R7: A locked read (op 2) or a write (op 3) from a source other than the owner of a locked address completes with status retry and leaves the lock unchanged.
- R8: A write (op 3) from the owner completes with status accepted and releases the lock. A write to an unlocked address is accepted.
- R9: When all NUM_LOCKS entries are held, a locked read to an address that is not already locked completes with status retry. Once an entry is released, the same request is accepted.
- R10: `cpl_status` is 0 for accepted and 1 for retry. Flag operations (op 0, op 1) are never retried. Lock operations (op 2, op 3) never change a flag and return `cpl_data`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 test-and-set, 1 clear, 2 locked read, 3 write |
| req_src | input | SRC_W | Requester ID |
| req_addr | input | ADDR_W | Target address; low bits select the flag |
| cpl_valid | output | 1 | Completion present |
| cpl_src | output | SRC_W | Requester ID of the completed request |
| cpl_status | output | 1 | 0 accepted, 1 retry |
| cpl_data | output | 1 | Previous flag value for a test-and-set, else 0 |

## Verification
The flag path is tested in three ways:
- A directed sequence on fresh flags separates correct reset and set behaviour from stale state.
- Back-to-back test-and-set requests on one flag from different sources expose any read-before-update hazard.
- Randomly timed bursts from many sources, each burst ended by a clear, check that exactly one requester wins in every round.

The lock table is tested in three ways as well:
- Directed owner versus non-owner sequences separate release from refusal.
- Filling every entry and then adding one more address exposes capacity handling.
- A long random mix of locked reads, writes and flag operations on a few addresses checks ordering and the independence of locks and flags against a reference model.

// File: rtl/tas_pkg.sv
package tas_pkg;

  typedef enum logic [1:0] {
    OP_TAS = 2'd0,
    OP_CLR = 2'd1,
    OP_LRD = 2'd2,
    OP_WR  = 2'd3
  } tas_op_e;

  localparam logic STAT_OK    = 1'b0;
  localparam logic STAT_RETRY = 1'b1;

endpackage

// File: rtl/tas_flag_array.sv
// Semaphore flag store: the read of the old value and the update share one cycle.
// NUM_FLAGS must be a power of two.
module tas_flag_array #(
  parameter int NUM_FLAGS = 8,
  localparam int IDX_W = $clog2(NUM_FLAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tas_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] idx,
  output logic             old_val
);

  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] flag_d;
  logic                 flag_we;

  assign old_val = flag_q[idx];

  always_comb begin
    flag_d  = flag_q;
    flag_we = tas_en | clr_en;
    if (tas_en) flag_d[idx] = 1'b1;
    if (clr_en) flag_d[idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_we) flag_q <= flag_d;
  end

  assert_tas_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tas_en |=> flag_q[$past(idx)]);

  assert_clr_clears_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !flag_q[$past(idx)]);

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tas_en && !clr_en) |=> $stable(flag_q));

endmodule

// File: rtl/tas_lock_table.sv
// Small associative table of address locks, each owned by one source.
module tas_lock_table #(
  parameter int NUM_LOCKS = 4,
  parameter int ADDR_W    = 16,
  parameter int SRC_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lrd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_W-1:0]  src,
  output logic              retry
);

  logic [NUM_LOCKS-1:0] valid_q, valid_d;
  logic [ADDR_W-1:0]    addr_q  [NUM_LOCKS];
  logic [ADDR_W-1:0]    addr_d  [NUM_LOCKS];
  logic [SRC_W-1:0]     owner_q [NUM_LOCKS];
  logic [SRC_W-1:0]     owner_d [NUM_LOCKS];

  logic [NUM_LOCKS-1:0] hit;
  logic [NUM_LOCKS-1:0] free_sel;
  logic [SRC_W-1:0]     hit_owner;
  logic                 hit_any, owner_match, full;
  logic                 alloc, release_lk, tbl_we;

  // lookup and first-free selection
  always_comb begin
    hit_owner = '0;
    free_sel  = '0;
    for (int i = 0; i < NUM_LOCKS; i++) begin
      hit[i] = valid_q[i] && (addr_q[i] == addr);
      if (hit[i]) hit_owner = hit_owner | owner_q[i];
    end
    for (int i = NUM_LOCKS - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_sel = NUM_LOCKS'(1) << i;
    end
  end

  assign hit_any     = |hit;
  assign owner_match = hit_any && (hit_owner == src);
  assign full        = &valid_q;

  assign retry = (lrd_en && ((hit_any && !owner_match) || (!hit_any && full))) ||
                 (wr_en && hit_any && !owner_match);

  assign alloc      = lrd_en && !hit_any && !full;
  assign release_lk = wr_en && owner_match;
  assign tbl_we     = alloc || release_lk;

  always_comb begin
    valid_d = valid_q;
    for (int i = 0; i < NUM_LOCKS; i++) begin
      addr_d[i]  = addr_q[i];
      owner_d[i] = owner_q[i];
      if (alloc && free_sel[i]) begin
        valid_d[i] = 1'b1;
        addr_d[i]  = addr;
        owner_d[i] = src;
      end
      if (release_lk && hit[i]) valid_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_LOCKS; i++) begin
        addr_q[i]  <= '0;
        owner_q[i] <= '0;
      end
    end else if (tbl_we) begin
      valid_q <= valid_d;
      for (int i = 0; i < NUM_LOCKS; i++) begin
        addr_q[i]  <= addr_d[i];
        owner_q[i] <= owner_d[i];
      end
    end
  end

  assert_one_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  assert_refused_keeps_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retry |=> $stable(valid_q));

  generate
    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_entry_chk
      assert_owner_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[g] |=> (!valid_q[g] || ($stable(owner_q[g]) && $stable(addr_q[g]))));
    end
  endgenerate

endmodule

// File: rtl/tas_unit.sv
module tas_unit
  import tas_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int NUM_SRC   = 8,
  parameter int ADDR_W    = 16,
  parameter int NUM_LOCKS = 4,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int FIDX_W   = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              cpl_valid,
  output logic [SRC_W-1:0]  cpl_src,
  output logic              cpl_status,
  output logic              cpl_data
);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  tas_op_e op;
  logic    is_tas, is_clr, is_lrd, is_wr;
  logic    flag_old, lock_retry;

  assign op     = tas_op_e'(req_op);
  assign is_tas = req_valid && (op == OP_TAS);
  assign is_clr = req_valid && (op == OP_CLR);
  assign is_lrd = req_valid && (op == OP_LRD);
  assign is_wr  = req_valid && (op == OP_WR);

  tas_flag_array #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tas_en  (is_tas),
    .clr_en  (is_clr),
    .idx     (req_addr[FIDX_W-1:0]),
    .old_val (flag_old)
  );

  tas_lock_table #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_locks (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lrd_en (is_lrd),
    .wr_en  (is_wr),
    .addr   (req_addr),
    .src    (req_src),
    .retry  (lock_retry)
  );

  // completion next state
  logic             cpl_valid_d, cpl_status_d, cpl_data_d;
  logic [SRC_W-1:0] cpl_src_d;

  always_comb begin
    cpl_valid_d  = req_valid;
    cpl_src_d    = req_src;
    cpl_status_d = lock_retry ? STAT_RETRY : STAT_OK;
    cpl_data_d   = is_tas ? flag_old : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cpl_valid  <= 1'b0;
      cpl_src    <= '0;
      cpl_status <= STAT_OK;
      cpl_data   <= 1'b0;
    end else begin
      cpl_valid <= cpl_valid_d;
      if (req_valid) begin
        cpl_src    <= cpl_src_d;
        cpl_status <= cpl_status_d;
        cpl_data   <= cpl_data_d;
      end
    end
  end

  assert_cpl_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> (cpl_valid && (cpl_src == $past(req_src))));

  assert_no_cpl_idle_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !cpl_valid);

  assert_flag_ops_not_retried_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (is_tas || is_clr) |=> (cpl_status == STAT_OK));

  assert_lock_ops_no_data_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (is_lrd || is_wr) |=> !cpl_data);

endmodule

// File: tb/test_tas_unit.sv
module test_tas_unit;
  import tas_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NF  = 8;
  localparam int NS  = 8;
  localparam int AW  = 16;
  localparam int NL  = 4;
  localparam int SW  = $clog2(NS);
  localparam int FW  = $clog2(NF);
  localparam int CF  = 5;          // contested flag
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [SW-1:0] req_src;
  logic [AW-1:0] req_addr;
  logic          cpl_valid, cpl_status, cpl_data;
  logic [SW-1:0] cpl_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  tas_unit #(.NUM_FLAGS(NF), .NUM_SRC(NS), .ADDR_W(AW), .NUM_LOCKS(NL)) i_tas_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_src(req_src), .req_addr(req_addr), .cpl_valid(cpl_valid),
    .cpl_src(cpl_src), .cpl_status(cpl_status), .cpl_data(cpl_data)
  );

  typedef struct packed {
    logic          contest;
    logic [1:0]    op;
    logic [SW-1:0] src;
    logic [FW-1:0] idx;
    logic          status;
    logic          data;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    zeros = 0;
  bit    done = 0;

  // reference model state
  bit            m_flag [NF];
  bit            m_lv   [NL];
  logic [AW-1:0] m_la   [NL];
  logic [SW-1:0] m_lo   [NL];

  task automatic send(input logic [1:0] op, input int src, input logic [AW-1:0] addr,
                      input bit contest, input string tag);
    exp_t e;
    int   hit;
    int   fr;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_src   = src[SW-1:0];
    req_addr  = addr;
    e.contest = contest;
    e.op      = op;
    e.src     = src[SW-1:0];
    e.idx     = addr[FW-1:0];
    e.status  = STAT_OK;
    e.data    = 1'b0;
    hit = -1;
    fr  = -1;
    for (int i = 0; i < NL; i++) begin
      if (m_lv[i] && m_la[i] == addr) hit = i;
      if (!m_lv[i] && fr < 0) fr = i;
    end
    case (op)
      OP_TAS: begin e.data = m_flag[addr[FW-1:0]]; m_flag[addr[FW-1:0]] = 1'b1; end
      OP_CLR: m_flag[addr[FW-1:0]] = 1'b0;
      OP_LRD: begin
        if (hit >= 0) begin
          if (m_lo[hit] != src[SW-1:0]) e.status = STAT_RETRY;
        end else if (fr >= 0) begin
          m_lv[fr] = 1'b1; m_la[fr] = addr; m_lo[fr] = src[SW-1:0];
        end else e.status = STAT_RETRY;
      end
      default: begin
        if (hit >= 0) begin
          if (m_lo[hit] != src[SW-1:0]) e.status = STAT_RETRY;
          else m_lv[hit] = 1'b0;
        end
      end
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (cpl_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: completion with no request outstanding (src %0d)", cpl_src);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (cpl_src !== e.src || cpl_status !== e.status || cpl_data !== e.data) begin
          n_fail++;
          $display("FAIL %s: op %0d src/status/data got %0d/%0d/%0d expected %0d/%0d/%0d",
                   t, e.op, cpl_src, cpl_status, cpl_data, e.src, e.status, e.data);
        end
        if (e.op == OP_TAS && e.idx == FW'(CF) && cpl_data === 1'b0) zeros++;
        if (e.op == OP_CLR && e.idx == FW'(CF)) begin
          if (e.contest) begin
            n_chk++;
            if (zeros != 1) begin
              n_fail++;
              $display("FAIL R5: winners in round got %0d expected 1", zeros);
            end
          end
          zeros = 0;
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s;
    s = $urandom(17);
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_src = '0; req_addr = '0;
    for (int i = 0; i < NF; i++) m_flag[i] = 1'b0;
    for (int i = 0; i < NL; i++) begin m_lv[i] = 1'b0; m_la[i] = '0; m_lo[i] = '0; end
    repeat (3) @(negedge clk);
    n_chk++;
    if (cpl_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1: cpl_valid in reset got %0b expected 0", cpl_valid);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (cpl_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1: cpl_valid after reset got %0b expected 0", cpl_valid);
    end

    // R1/R3: every flag starts clear; test-and-set sets it (upper address bits ignored)
    for (int f = 0; f < NF; f++) send(OP_TAS, f, AW'(16'h3a00 | f), 0, "R1");
    for (int f = 0; f < NF; f++) send(OP_TAS, 7 - f, AW'(16'h0100 | f), 0, "R3");
    // R4: clear then set again
    send(OP_CLR, 2, AW'(3), 0, "R4");
    send(OP_TAS, 4, AW'(3), 0, "R4");
    send(OP_TAS, 6, AW'(3), 0, "R4");
    idle(2);
    // R5: back-to-back contest from different sources
    send(OP_CLR, 0, AW'(CF), 0, "R5");
    send(OP_TAS, 1, AW'(CF), 0, "R5");
    send(OP_TAS, 2, AW'(CF), 0, "R5");
    send(OP_TAS, 3, AW'(CF), 0, "R5");
    send(OP_CLR, 0, AW'(CF), 1, "R5");
    idle(3);

    // R6/R7/R8: lock ownership
    send(OP_LRD, 1, 16'h1200, 0, "R6");
    send(OP_WR,  2, 16'h1200, 0, "R7");
    send(OP_LRD, 2, 16'h1200, 0, "R7");
    send(OP_LRD, 1, 16'h1200, 0, "R6");
    send(OP_WR,  2, 16'h1204, 0, "R8");
    send(OP_TAS, 5, 16'h1200, 0, "R10");
    send(OP_WR,  1, 16'h1200, 0, "R8");
    send(OP_WR,  2, 16'h1200, 0, "R8");
    idle(2);

    // R9: fill every entry, one more is refused, release, then accepted
    for (int i = 0; i < NL; i++) send(OP_LRD, i, AW'(16'h2000 + i), 0, "R9");
    send(OP_LRD, 6, 16'h2100, 0, "R9");
    send(OP_LRD, 2, 16'h2002, 0, "R9");
    send(OP_WR,  5, 16'h2001, 0, "R7");
    send(OP_WR,  1, 16'h2001, 0, "R9");
    send(OP_LRD, 6, 16'h2100, 0, "R9");
    send(OP_LRD, 7, 16'h2200, 0, "R9");
    for (int i = 0; i < NL; i++) send(OP_WR, i, AW'(16'h2000 + i), 0, "R8");
    send(OP_WR, 6, 16'h2100, 0, "R8");
    idle(3);

    // R5: random-timed contention rounds on one flag
    send(OP_CLR, 0, AW'(CF), 0, "R5");
    for (int r = 0; r < 40; r++) begin
      int k;
      k = 2 + int'($urandom_range(0, 5));
      for (int j = 0; j < k; j++) begin
        send(OP_TAS, int'($urandom_range(0, NS - 1)),
             AW'({$urandom_range(0, 255), 3'(CF)}), 0, "R5");
        idle(int'($urandom_range(0, 3)));
      end
      send(OP_CLR, int'($urandom_range(0, NS - 1)), AW'(CF), 1, "R5");
      idle(int'($urandom_range(0, 2)));
    end
    idle(3);

    // R7/R10: random mix of lock and flag traffic on few addresses
    for (int n = 0; n < 400; n++) begin
      send(2'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
           AW'(16'h4000 + $urandom_range(0, 5)), 0, "R7");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(5);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: outstanding completions got %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule